// File: doc/BRIEF.md
# Multi-Mode Dual-Reload Timer

This block is a down-counting timer with two companion registers, A and B. Each register has its own pending flag and its own interrupt enable, and the block has one combined interrupt request. A two-bit mode field picks one of three behaviours:

- **Waveform generation.** Every expiry reloads the counter from A and from B in turn, and can toggle an output pin. The two reload values set the high time and the low time of the waveform. The interrupt can follow either edge of the waveform, or both.
- **Event counting.** The counter steps once per selected edge on input pin A. The second input pin then works as an independent rising-edge interrupt source.
- **Capture.** The counter runs freely, and edges on the two pins latch its value into A and B.

Software reaches every register through a small write bus and a combinational read port. Both input pins pass through a synchronizer before any logic sees them.

Top module: `dual_reload_timer`

## Requirements
- R1: After reset, the counter, A, B, control and both pending flags read as zero, and `irq` and `pinAOut` are low.
- R2: In mode 00 with run set, the counter falls by one per clock. In a cycle where it is zero, it reloads instead. The first reload after a control write comes from A, and the reloads then alternate A, B, A, and so on.
- R3: A reload in mode 00 inverts `pinAOut` when the toggle-enable bit is set. In every other case `pinAOut` keeps its value.
- R4: A reload from A sets pending flag A. A reload from B sets pending flag B.
- R5: `irq` equals (pending A AND enable A) OR (pending B AND enable B).
- R6: Writing address 4 clears pending A when data bit 0 is 1, and clears pending B when data bit 1 is 1. A flag set by hardware in the same cycle as a clear stays set.
- R7: Mode 01 counts rising edges of pin A, and mode 10 counts falling edges of pin A. A counted edge that finds the counter at zero reloads it from A and sets pending A. These modes never toggle `pinAOut`.
- R8: In modes 01 and 10, a rising edge on pin B sets pending B.
- R9: In mode 11 with run set, the counter falls by one per clock and wraps from 0 to all ones.
- R10: In mode 11, a rising edge on pin A copies the counter into A and sets pending A. Pin B does the same for B and pending B. A capture overrides a bus write to the same register in that cycle.
- R11: A pin change that is present before clock edge k takes effect in the state seen after edge k+2.
- R12: With run clear, the counter holds. A bus write to address 0 always loads the counter, and it overrides any reload or decrement in that cycle.
- R13: The register addresses are 0 counter, 1 A, 2 B, 3 control and 4 flags (bit 0 is A, bit 1 is B). The control bits are [1:0] mode, [2] run, [3] toggle enable, [4] enable A and [5] enable B. Writing control restarts the reload alternation at A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busAddr | input | ADDR_W | Register address for write and read |
| busWrEn | input | 1 | Write strobe |
| busWrData | input | CNT_W | Write data |
| busRdData | output | CNT_W | Combinational read data for `busAddr` |
| pinAIn | input | 1 | Pin A input (event or capture source) |
| pinBIn | input | 1 | Pin B input (edge interrupt or capture source) |
| pinAOut | output | 1 | Waveform output |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with its default 16-bit counter and 3-bit address.

Short reload values (1 to 5) make expiries arrive every few clocks. Flag clears therefore collide with hardware sets, and the A/B alternation wraps many times. Loading the counter with 1 in capture mode brings the wrap from 0 to all ones within reach in a few cycles.

Pin patterns with periods that are prime to each other make capture edges land on cycles with bus writes to the same register.

// File: rtl/timer_pkg.sv
package timer_pkg;

  typedef enum logic [1:0] {
    MODE_PWM     = 2'b00,
    MODE_EV_RISE = 2'b01,
    MODE_EV_FALL = 2'b10,
    MODE_CAPTURE = 2'b11
  } mode_e;

  // Packed so that bit 0..1 is mode, 2 run, 3 toggle, 4 enA, 5 enB
  typedef struct packed {
    logic  enB;
    logic  enA;
    logic  togEn;
    logic  run;
    mode_e mode;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);

  typedef struct packed {
    logic dec;
    logic loadA;
    logic loadB;
    logic setA;
    logic setB;
    logic capA;
    logic capB;
    logic toggle;
  } strobe_t;

  localparam int ADDR_CNT  = 0;
  localparam int ADDR_REGA = 1;
  localparam int ADDR_REGB = 2;
  localparam int ADDR_CTL  = 3;
  localparam int ADDR_FLG  = 4;

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] stage;
  logic              prevQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage <= '0;
      prevQ <= 1'b0;
    end else begin
      stage <= {stage[STAGES-2:0], din};
      prevQ <= stage[STAGES-1];
    end
  end

  assign rise = stage[STAGES-1] & ~prevQ;
  assign fall = ~stage[STAGES-1] & prevQ;
endmodule

// File: rtl/timer_ctrl.sv
module timer_ctrl
  import timer_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rst_n,
  input  cfg_t    cfg,
  input  logic    cntZero,
  input  logic    ctlWrite,
  input  logic    pinAIn,
  input  logic    pinBIn,
  output strobe_t stb
);
  localparam int NUM_PINS = 2;

  logic [NUM_PINS-1:0] pinRaw, pinRise, pinFall;
  logic                selB;
  logic                evTick;

  assign pinRaw = {pinBIn, pinAIn};

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_sync
    pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (pinRaw[p]),
      .rise (pinRise[p]),
      .fall (pinFall[p])
    );
  end

  assign evTick = (cfg.mode == MODE_EV_RISE) ? pinRise[0] : pinFall[0];

  always_comb begin
    stb = '0;
    unique case (cfg.mode)
      MODE_PWM: begin
        if (cfg.run) begin
          if (cntZero) begin
            stb.loadA  = ~selB;
            stb.setA   = ~selB;
            stb.loadB  = selB;
            stb.setB   = selB;
            stb.toggle = cfg.togEn;
          end else begin
            stb.dec = 1'b1;
          end
        end
      end
      MODE_EV_RISE, MODE_EV_FALL: begin
        if (cfg.run && evTick) begin
          if (cntZero) begin
            stb.loadA = 1'b1;
            stb.setA  = 1'b1;
          end else begin
            stb.dec = 1'b1;
          end
        end
        stb.setB = pinRise[1];
      end
      MODE_CAPTURE: begin
        stb.dec  = cfg.run;
        stb.capA = pinRise[0];
        stb.setA = pinRise[0];
        stb.capB = pinRise[1];
        stb.setB = pinRise[1];
      end
      default: stb = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      selB <= 1'b0;
    else if (ctlWrite)               selB <= 1'b0;
    else if (stb.loadA || stb.loadB) selB <= ~selB;
  end
endmodule

// File: rtl/timer_dpath.sv
module timer_dpath
  import timer_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strobe_t           stb,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [CNT_W-1:0]  busWrData,
  output logic [CNT_W-1:0]  busRdData,
  output cfg_t              cfg,
  output logic              cntZero,
  output logic              ctlWrite,
  output logic [CNT_W-1:0]  cntVal,
  output logic              pendA,
  output logic              pendB,
  output logic              pinAOut
);
  localparam int FLG_W = 2;

  logic [CNT_W-1:0] cntQ, regAQ, regBQ;
  cfg_t             cfgQ;
  logic             pendAQ, pendBQ, outQ;
  logic             wrCnt, wrA, wrB, wrFlg;
  logic             clrA, clrB;

  assign wrCnt    = busWrEn && (busAddr == ADDR_W'(ADDR_CNT));
  assign wrA      = busWrEn && (busAddr == ADDR_W'(ADDR_REGA));
  assign wrB      = busWrEn && (busAddr == ADDR_W'(ADDR_REGB));
  assign ctlWrite = busWrEn && (busAddr == ADDR_W'(ADDR_CTL));
  assign wrFlg    = busWrEn && (busAddr == ADDR_W'(ADDR_FLG));
  assign clrA     = wrFlg && busWrData[0];
  assign clrB     = wrFlg && busWrData[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cntQ <= '0;
    else if (wrCnt)     cntQ <= busWrData;
    else if (stb.loadA) cntQ <= regAQ;
    else if (stb.loadB) cntQ <= regBQ;
    else if (stb.dec)   cntQ <= cntQ - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        regAQ <= '0;
    else if (stb.capA) regAQ <= cntQ;
    else if (wrA)      regAQ <= busWrData;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        regBQ <= '0;
    else if (stb.capB) regBQ <= cntQ;
    else if (wrB)      regBQ <= busWrData;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cfgQ <= '0;
    else if (ctlWrite) cfgQ <= cfg_t'(busWrData[CFG_W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pendAQ <= 1'b0;
      pendBQ <= 1'b0;
    end else begin
      pendAQ <= (pendAQ & ~clrA) | stb.setA;
      pendBQ <= (pendBQ & ~clrB) | stb.setB;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          outQ <= 1'b0;
    else if (stb.toggle) outQ <= ~outQ;
  end

  always_comb begin
    busRdData = '0;
    case (busAddr)
      ADDR_W'(ADDR_CNT):  busRdData = cntQ;
      ADDR_W'(ADDR_REGA): busRdData = regAQ;
      ADDR_W'(ADDR_REGB): busRdData = regBQ;
      ADDR_W'(ADDR_CTL):  busRdData = CNT_W'(cfgQ);
      ADDR_W'(ADDR_FLG):  busRdData = CNT_W'({pendBQ, pendAQ});
      default:            busRdData = '0;
    endcase
  end

  assign cfg     = cfgQ;
  assign cntZero = (cntQ == '0);
  assign cntVal  = cntQ;
  assign pendA   = pendAQ;
  assign pendB   = pendBQ;
  assign pinAOut = outQ;
endmodule

// File: rtl/dual_reload_timer.sv
module dual_reload_timer
  import timer_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [CNT_W-1:0]  busWrData,
  output logic [CNT_W-1:0]  busRdData,
  input  logic              pinAIn,
  input  logic              pinBIn,
  output logic              pinAOut,
  output logic              irq
);
  strobe_t          stb;
  cfg_t             cfgQ;
  logic             cntZero, ctlWrite, pendA, pendB;
  logic [CNT_W-1:0] cntVal;

  timer_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg     (cfgQ),
    .cntZero (cntZero),
    .ctlWrite(ctlWrite),
    .pinAIn  (pinAIn),
    .pinBIn  (pinBIn),
    .stb     (stb)
  );

  timer_dpath #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_dpath (
    .clk      (clk),
    .rst_n    (rst_n),
    .stb      (stb),
    .busAddr  (busAddr),
    .busWrEn  (busWrEn),
    .busWrData(busWrData),
    .busRdData(busRdData),
    .cfg      (cfgQ),
    .cntZero  (cntZero),
    .ctlWrite (ctlWrite),
    .cntVal   (cntVal),
    .pendA    (pendA),
    .pendB    (pendB),
    .pinAOut  (pinAOut)
  );

  assign irq = (pendA & cfgQ.enA) | (pendB & cfgQ.enB);
endmodule

// File: rtl/timer_checker.sv
module timer_checker
  import timer_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrEn,
  input logic [CNT_W-1:0]  busWrData,
  input logic              irq,
  input logic              pinAOut,
  input logic [CNT_W-1:0]  cnt,
  input cfg_t              cfg,
  input logic              pendA,
  input logic              pendB
);
  logic wrCnt, wrFlg;
  assign wrCnt = busWrEn && (busAddr == ADDR_W'(ADDR_CNT));
  assign wrFlg = busWrEn && (busAddr == ADDR_W'(ADDR_FLG));

  // R5
  no_flag_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pendA && !pendB) |-> !irq);

  // R6
  flag_a_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pendA && !(wrFlg && busWrData[0])) |=> pendA);

  // R6
  flag_b_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pendB && !(wrFlg && busWrData[1])) |=> pendB);

  // R12
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg.run && !wrCnt) |=> $stable(cnt));

  // R3
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.mode != MODE_PWM || !cfg.togEn) |=> $stable(pinAOut));

  // R2
  pwm_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.mode == MODE_PWM && cfg.run && cnt != '0 && !wrCnt)
      |=> cnt == CNT_W'($past(cnt) - CNT_W'(1)));

  // R9
  cap_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.mode == MODE_CAPTURE && cfg.run && !wrCnt)
      |=> cnt == CNT_W'($past(cnt) - CNT_W'(1)));
endmodule

bind dual_reload_timer timer_checker #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busAddr  (busAddr),
  .busWrEn  (busWrEn),
  .busWrData(busWrData),
  .irq      (irq),
  .pinAOut  (pinAOut),
  .cnt      (cntVal),
  .cfg      (cfgQ),
  .pendA    (pendA),
  .pendB    (pendB)
);

// File: tb/dual_reload_timer_tb.sv
module dual_reload_timer_tb;
  localparam int CNT_W  = 16;
  localparam int ADDR_W = 3;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [ADDR_W-1:0] busAddr = '0;
  logic              busWrEn = 1'b0;
  logic [CNT_W-1:0]  busWrData = '0;
  logic [CNT_W-1:0]  busRdData;
  logic              pinAIn = 1'b0, pinBIn = 1'b0;
  logic              pinAOut, irq;

  int    nChecks = 0, nFails = 0, cyc = 0, rot = 0, pinPat = 0;
  bit    started = 0, done = 0;
  string phase = "R1";

  dual_reload_timer #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .pinAIn(pinAIn),
    .pinBIn(pinBIn), .pinAOut(pinAOut), .irq(irq)
  );

  always #5 clk = ~clk;

  // behavioural reference state
  logic [CNT_W-1:0] mCnt = '0, mA = '0, mB = '0;
  logic [5:0]       mCtl = '0;
  logic             mPa = 0, mPb = 0, mOut = 0, mSel = 0;
  logic             a1 = 0, a2 = 0, ap = 0, b1 = 0, b2 = 0, bp = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      mCnt = '0; mA = '0; mB = '0; mCtl = '0;
      mPa = 0; mPb = 0; mOut = 0; mSel = 0;
      a1 = 0; a2 = 0; ap = 0; b1 = 0; b2 = 0; bp = 0;
    end else begin
      logic rA, fA, rB, setA, setB, capA, capB, nSel, nOut;
      logic [CNT_W-1:0] nCnt, nA, nB;
      logic [5:0] nCtl;
      logic nPa, nPb;
      rA = a2 & ~ap; fA = ~a2 & ap; rB = b2 & ~bp;
      setA = 0; setB = 0; capA = 0; capB = 0;
      nCnt = mCnt; nA = mA; nB = mB; nCtl = mCtl; nSel = mSel; nOut = mOut;
      case (mCtl[1:0])
        2'd0: if (mCtl[2]) begin
          if (mCnt == 0) begin
            if (!mSel) begin nCnt = mA; setA = 1; end
            else       begin nCnt = mB; setB = 1; end
            nSel = ~mSel;
            if (mCtl[3]) nOut = ~mOut;
          end else nCnt = mCnt - 1;
        end
        2'd1, 2'd2: begin
          if (mCtl[2] && ((mCtl[1:0] == 2'd1) ? rA : fA)) begin
            if (mCnt == 0) begin nCnt = mA; setA = 1; end
            else nCnt = mCnt - 1;
          end
          if (rB) setB = 1;
        end
        default: begin
          if (mCtl[2]) nCnt = mCnt - 1;
          if (rA) begin nA = mCnt; setA = 1; capA = 1; end
          if (rB) begin nB = mCnt; setB = 1; capB = 1; end
        end
      endcase
      nPa = mPa; nPb = mPb;
      if (busWrEn) begin
        case (int'(busAddr))
          0: nCnt = busWrData;
          1: if (!capA) nA = busWrData;
          2: if (!capB) nB = busWrData;
          3: begin nCtl = busWrData[5:0]; nSel = 0; end
          4: begin if (busWrData[0]) nPa = 0; if (busWrData[1]) nPb = 0; end
          default: ;
        endcase
      end
      if (setA) nPa = 1;
      if (setB) nPb = 1;
      mCnt = nCnt; mA = nA; mB = nB; mCtl = nCtl; mSel = nSel; mOut = nOut;
      mPa = nPa; mPb = nPb;
      ap = a2; a2 = a1; a1 = pinAIn;
      bp = b2; b2 = b1; b1 = pinBIn;
    end
    if (rst_n) started = 1;
  end

  function automatic logic [CNT_W-1:0] modelRead(int a);
    case (a)
      0: return mCnt;
      1: return mA;
      2: return mB;
      3: return CNT_W'(mCtl);
      4: return CNT_W'({mPb, mPa});
      default: return '0;
    endcase
  endfunction

  task automatic check(string tag, string what, logic [CNT_W-1:0] act, logic [CNT_W-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s actual %h expected %h (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  // compare away from the active edge
  always @(negedge clk) begin
    if (started && !done) begin
      check(phase, "busRdData", busRdData, modelRead(int'(busAddr)));
      check("R5", "irq", CNT_W'(irq), CNT_W'((mPa & mCtl[4]) | (mPb & mCtl[5])));
      check("R3", "pinAOut", CNT_W'(pinAOut), CNT_W'(mOut));
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      busWrEn = 0; busAddr = ADDR_W'(rot); rot = (rot + 1) % 5; cyc++;
      case (pinPat)
        1: begin pinAIn = (cyc / 3) % 2 == 1; pinBIn = (cyc % 7) < 2; end
        2: begin pinAIn = (cyc % 11) < 3; pinBIn = (cyc % 13) < 4; end
        default: ;
      endcase
    end
  endtask

  task automatic wr(int a, int d);
    @(posedge clk); #1;
    busWrEn = 1; busAddr = ADDR_W'(a); busWrData = CNT_W'(d); cyc++;
  endtask

  initial begin
    rst_n = 0;
    idle(4);            // R1 reset state compared on every address
    rst_n = 1;
    idle(6);
    // R2 R4 alternating reloads, toggling output
    phase = "R2";
    wr(1, 5); wr(2, 3); wr(0, 2);
    wr(3, 32'h1C);      // PWM, run, toggle, enA
    idle(60);
    phase = "R6";       // clears colliding with short reload periods
    wr(1, 1); wr(2, 1);
    for (int k = 0; k < 20; k++) begin wr(4, (k % 3) + 1); idle(k % 4); end
    phase = "R3";
    wr(3, 32'h34);      // PWM, run, toggle off, enA enB
    idle(30);
    // R7 R8 R11 rising-edge event counting
    phase = "R7";
    wr(4, 3); wr(1, 2); wr(0, 3);
    wr(3, 32'h35);
    pinPat = 1; idle(80);
    phase = "R8";
    wr(3, 32'h36);      // falling edges
    idle(80);
    pinPat = 0;
    // R12 stall and counter override
    phase = "R12";
    wr(3, 32'h30); wr(0, 9); idle(10);
    wr(3, 32'h04); wr(0, 7); idle(5);
    // R9 R10 capture, wrap through zero, capture vs write collisions
    phase = "R10";
    wr(4, 3); wr(0, 1);
    wr(3, 32'h37);
    idle(3);            // R9 wrap
    pinPat = 2;
    for (int k = 0; k < 30; k++) begin wr(1 + (k % 2), k); idle(k % 5); end
    idle(40);
    pinPat = 0;
    phase = "R13";
    wr(3, 32'h3F); idle(10);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      nChecks++; nFails++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule